// File: doc/BRIEF.md
# Weighted Interleave Node Selector

This block chooses a destination node for each allocation request so that, over time, the requests are spread across a group of nodes. A bitmask says which nodes take part. In plain mode each participating node receives one grant per round. In weighted mode each node receives a run of back-to-back grants as long as its programmed weight. After that run the selector moves to the next participating node in ascending index order, and wraps from the top index back to the lowest.

Each node also reports whether it can currently take an allocation. When the node whose turn it is cannot, the grant falls back to the next node that is both participating and able, searching upward with wrap. A fallback grant does not use up any of the waiting node's run. It therefore upsets the ratio only for the requests that were diverted.

Configuration is loaded with a strobe. The strobe restarts the rotation at the lowest participating node with that node's full run. A grant appears one clock after its request, and requests may arrive on every clock.

Top module: `node_spread_sel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `grant_vld_o` is 0 and `grant_node_o` is 0.
- R2: `grant_vld_o` is 1 only in the cycle directly after a cycle in which `req_i` was 1 and `cfg_load_i` was 0.
- R3: Turns pass between participating nodes (bit i of `en_mask_i` set means node i participates) in ascending index order, wrapping from the highest to the lowest. Non-participating nodes are never granted.
- R4: With `weighted_i` = 0 (plain mode) and every node able, each participating node receives exactly one grant per round. Two nodes 0 and 1 give 0,1,0,1.
- R5: With `weighted_i` = 1, a node receives as many consecutive grants as its weight (field i of `wgt_flat_i`, bits [i*WGT_W +: WGT_W]). Weights 2,1 on nodes 0,1 give 0,0,1,0,0,1. Mask {0,2,5} with weights 4,7,9 gives counts in the ratio 4:7:9 over whole rounds.
- R6: A weight of 0 acts as a weight of 1, so a participating node is never skipped for that reason.
- R7: If the node whose turn it is has `node_avail_i` low, the grant goes to the next participating node with `node_avail_i` high, searching upward with wrap. The waiting node keeps its turn and its remaining run.
- R8: If the mask is empty, or no participating node is able, a request yields `grant_vld_o` = 0 and the rotation state is unchanged.
- R9: A cycle with `cfg_load_i` = 1 restarts the rotation at the lowest participating node with its full run. A request in that same cycle is dropped.
- R10: Requests on consecutive cycles each yield a grant on the following cycle whenever some participating node is able.
- R11: Every grant names a node that was both participating and able in the cycle of its request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_load_i | input | 1 | Restart the rotation from the current mask, weights and mode |
| en_mask_i | input | NODES | Participating-node bitmask |
| wgt_flat_i | input | NODES*WGT_W | Per-node weights, node i in bits [i*WGT_W +: WGT_W] |
| weighted_i | input | 1 | 1 = weighted runs, 0 = one grant per turn |
| req_i | input | 1 | Allocation request strobe |
| node_avail_i | input | NODES | Per-node capacity flag, 1 = can accept |
| grant_vld_o | output | 1 | A grant is presented this cycle |
| grant_node_o | output | IDX_W | Index of the granted node |

## Verification
The hardest situation to reach is a fallback that happens in the middle of a weighted run. The bench then has to confirm that the diverted grant left the waiting node's remaining run untouched, and that the rotation later resumes exactly where it stopped. A directed sequence sets up a run of three on node 0. It takes one grant, then drops node 0's capacity for one request, restores it, and expects two more grants on node 0 before the turn moves on. A wrap-around fallback from the top participating node follows. The random phase then lowers capacity flags on about one cycle in five while requests keep arriving, so that fallbacks land at many different points in runs of differing length.

// File: rtl/nsel_pkg.sv
package nsel_pkg;

   typedef enum logic {
      SEL_PLAIN    = 1'b0,
      SEL_WEIGHTED = 1'b1
   } sel_mode_e;

endpackage

// File: rtl/nsel_ring_find.sv
// Finds the first set bit of vec_i at or above start_i, wrapping past the top.
module nsel_ring_find #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic [N-1:0]     vec_i,
   input  logic [IDX_W-1:0] start_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);

   localparam bit POW2 = ((1 << IDX_W) == N);

   logic [2*N-1:0]   dbl_w;
   logic [N-1:0]     rot_w;
   logic [IDX_W-1:0] off_w;

   assign dbl_w   = {vec_i, vec_i} >> start_i;
   assign rot_w   = dbl_w[N-1:0];
   assign found_o = |vec_i;

   always_comb begin
      off_w = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (rot_w[i]) off_w = IDX_W'(i);
      end
   end

   generate
      if (POW2) begin : g_wrap_free
         assign idx_o = start_i + off_w;
      end else begin : g_wrap_sub
         logic [IDX_W:0] sum_w;
         assign sum_w = {1'b0, start_i} + {1'b0, off_w};
         assign idx_o = (sum_w >= (IDX_W + 1)'(N)) ? IDX_W'(sum_w - (IDX_W + 1)'(N))
                                                   : sum_w[IDX_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/nsel_weight_mux.sv
// Selects one node's weight and turns it into a run length (never zero).
module nsel_weight_mux
   import nsel_pkg::*;
#(
   parameter int N     = 16,
   parameter int W     = 8,
   parameter int IDX_W = 4
) (
   input  logic [N*W-1:0]   wgt_flat_i,
   input  logic [IDX_W-1:0] idx_i,
   input  sel_mode_e        mode_i,
   output logic [W-1:0]     run_o
);

   logic [W-1:0] wtab [N];
   logic [W-1:0] raw_w;

   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_unpack
         assign wtab[g] = wgt_flat_i[g*W +: W];
      end
   endgenerate

   assign raw_w = (int'(idx_i) < N) ? wtab[idx_i] : '0;
   assign run_o = (mode_i == SEL_PLAIN || raw_w == '0) ? W'(1) : raw_w;

endmodule

// File: rtl/node_spread_sel.sv
module node_spread_sel
   import nsel_pkg::*;
#(
   parameter int NODES = 16,
   parameter int WGT_W = 8,
   localparam int IDX_W = $clog2(NODES)
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   cfg_load_i,
   input  logic [NODES-1:0]       en_mask_i,
   input  logic [NODES*WGT_W-1:0] wgt_flat_i,
   input  logic                   weighted_i,
   input  logic                   req_i,
   input  logic [NODES-1:0]       node_avail_i,
   output logic                   grant_vld_o,
   output logic [IDX_W-1:0]       grant_node_o
);

   generate
      if (NODES < 2 || NODES > 16) begin : g_bad_nodes
         $error("node_spread_sel: NODES must lie in 2..16");
      end
      if (WGT_W < 1 || WGT_W > 16) begin : g_bad_wgt
         $error("node_spread_sel: WGT_W must lie in 1..16");
      end
   endgenerate

   sel_mode_e        mode_w;
   logic [NODES-1:0] elig_w;
   logic [IDX_W-1:0] cur_q, cur_d;
   logic [WGT_W-1:0] cred_q, cred_d;
   logic             vld_d;
   logic [IDX_W-1:0] node_d;
   logic [IDX_W-1:0] nxt_start_w;

   logic             pick_found_w, next_found_w, low_found_w;
   logic [IDX_W-1:0] pick_idx_w, next_idx_w, low_idx_w;
   logic [WGT_W-1:0] next_run_w, low_run_w;

   assign mode_w      = sel_mode_e'(weighted_i);
   assign elig_w      = en_mask_i & node_avail_i;
   assign nxt_start_w = (cur_q == IDX_W'(NODES - 1)) ? '0 : cur_q + IDX_W'(1);

   // node that actually gets this request (current turn or fallback)
   nsel_ring_find #(.N(NODES), .IDX_W(IDX_W)) u_pick (
      .vec_i(elig_w), .start_i(cur_q), .found_o(pick_found_w), .idx_o(pick_idx_w)
   );

   // node whose turn follows the current one
   nsel_ring_find #(.N(NODES), .IDX_W(IDX_W)) u_next (
      .vec_i(en_mask_i), .start_i(nxt_start_w), .found_o(next_found_w), .idx_o(next_idx_w)
   );

   // restart point after a configuration load
   nsel_ring_find #(.N(NODES), .IDX_W(IDX_W)) u_low (
      .vec_i(en_mask_i), .start_i('0), .found_o(low_found_w), .idx_o(low_idx_w)
   );

   nsel_weight_mux #(.N(NODES), .W(WGT_W), .IDX_W(IDX_W)) u_run_next (
      .wgt_flat_i(wgt_flat_i), .idx_i(next_idx_w), .mode_i(mode_w), .run_o(next_run_w)
   );

   nsel_weight_mux #(.N(NODES), .W(WGT_W), .IDX_W(IDX_W)) u_run_low (
      .wgt_flat_i(wgt_flat_i), .idx_i(low_idx_w), .mode_i(mode_w), .run_o(low_run_w)
   );

   always_comb begin
      cur_d  = cur_q;
      cred_d = cred_q;
      vld_d  = 1'b0;
      node_d = grant_node_o;
      if (cfg_load_i) begin
         cur_d  = low_found_w ? low_idx_w : '0;
         cred_d = low_run_w;
      end else if (req_i && pick_found_w) begin
         vld_d  = 1'b1;
         node_d = pick_idx_w;
         if (pick_idx_w == cur_q) begin
            if (mode_w == SEL_WEIGHTED && cred_q > WGT_W'(1)) begin
               cred_d = cred_q - WGT_W'(1);
            end else if (next_found_w) begin
               cur_d  = next_idx_w;
               cred_d = next_run_w;
            end
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cur_q        <= '0;
         cred_q       <= WGT_W'(1);
         grant_vld_o  <= 1'b0;
         grant_node_o <= '0;
      end else begin
         cur_q        <= cur_d;
         cred_q       <= cred_d;
         grant_vld_o  <= vld_d;
         grant_node_o <= node_d;
      end
   end

endmodule

// File: rtl/nsel_checker.sv
module nsel_checker #(
   parameter int NODES = 16,
   parameter int WGT_W = 8,
   parameter int IDX_W = 4
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             cfg_load_i,
   input logic [NODES-1:0] en_mask_i,
   input logic             req_i,
   input logic [NODES-1:0] node_avail_i,
   input logic             grant_vld_o,
   input logic [IDX_W-1:0] grant_node_o,
   input logic [IDX_W-1:0] cur_q,
   input logic [WGT_W-1:0] cred_q
);

   logic [NODES-1:0] elig_c;
   logic [NODES-1:0] gnt_oh_c;

   assign elig_c   = en_mask_i & node_avail_i;
   assign gnt_oh_c = {{(NODES-1){1'b0}}, 1'b1} << grant_node_o;

   // R2
   no_req_no_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i |=> !grant_vld_o);

   // R9
   load_drops_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_load_i |=> !grant_vld_o);

   // R8
   idle_keeps_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && !cfg_load_i && elig_c == '0) |=> (!grant_vld_o && $stable(cur_q) && $stable(cred_q)));

   // R10
   grant_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && !cfg_load_i && elig_c != '0) |=> grant_vld_o);

   // R11
   grant_target_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_vld_o |-> (($past(elig_c) & gnt_oh_c) != '0));

   // R6
   credit_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cred_q != '0);

endmodule

bind node_spread_sel nsel_checker #(.NODES(NODES), .WGT_W(WGT_W), .IDX_W(IDX_W)) u_nsel_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .cfg_load_i(cfg_load_i), .en_mask_i(en_mask_i),
   .req_i(req_i), .node_avail_i(node_avail_i), .grant_vld_o(grant_vld_o),
   .grant_node_o(grant_node_o), .cur_q(cur_q), .cred_q(cred_q)
);

// File: tb/node_spread_sel_bench.sv
module node_spread_sel_bench;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int N = 16;
   localparam int W = 8;
   localparam int IW = $clog2(N);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cfg_load = 1'b0;
   logic [N-1:0]   en_mask = '0;
   logic [N*W-1:0] wgt_flat;
   logic           weighted = 1'b0;
   logic           req = 1'b0;
   logic [N-1:0]   avail = '1;
   logic           grant_vld;
   logic [IW-1:0]  grant_node;
   logic [W-1:0]   wt [N];

   int checks = 0;
   int fails = 0;
   bit done = 0;
   int m_cur = 0;
   int m_cred = 1;

   always #2.5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < N; i++) wgt_flat[i*W +: W] = wt[i];
   end

   node_spread_sel #(.NODES(N), .WGT_W(W)) u_node_spread_sel (
      .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .en_mask_i(en_mask),
      .wgt_flat_i(wgt_flat), .weighted_i(weighted), .req_i(req),
      .node_avail_i(avail), .grant_vld_o(grant_vld), .grant_node_o(grant_node)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int run_len(int n);
      if (!weighted) return 1;
      if (wt[n] == 0) return 1;
      return int'(wt[n]);
   endfunction

   function automatic int lowest_en();
      for (int i = 0; i < N; i++) if (en_mask[i]) return i;
      return 0;
   endfunction

   // expected behaviour for one clock, taken from the requirements
   task automatic model(input bit r, input bit ld, output bit ev, output int en);
      int p;
      ev = 0; en = 0; p = -1;
      if (ld) begin
         m_cur  = lowest_en();
         m_cred = run_len(m_cur);
      end else if (r) begin
         for (int k = 0; k < N; k++) begin
            int j = (m_cur + k) % N;
            if (p < 0 && en_mask[j] && avail[j]) p = j;
         end
         if (p >= 0) begin
            ev = 1; en = p;
            if (p == m_cur) begin
               if (weighted && m_cred > 1) m_cred--;
               else begin
                  for (int k = 1; k <= N; k++) begin
                     int j = (m_cur + k) % N;
                     if (en_mask[j]) begin
                        m_cur  = j;
                        m_cred = run_len(j);
                        break;
                     end
                  end
               end
            end
         end
      end
   endtask

   task automatic cyc(input bit r, input bit ld, output bit gv, output int gn);
      bit ev; int en;
      @(negedge clk);
      req = r; cfg_load = ld;
      model(r, ld, ev, en);
      @(posedge clk); #1;
      gv = grant_vld; gn = int'(grant_node);
      chk(gv == ev, "R2 R10 R11 grant_vld", int'(gv), int'(ev));
      if (ev) chk(gn == en, "R3 R7 grant_node", gn, en);
   endtask

   task automatic load(input logic [N-1:0] m, input bit wmode);
      bit gv; int gn;
      @(negedge clk);
      en_mask = m; weighted = wmode;
      cyc(0, 1, gv, gn);
   endtask

   task automatic expect_node(input int exp, input string tag);
      bit gv; int gn;
      cyc(1, 0, gv, gn);
      chk(gv && gn == exp, tag, gv ? gn : -1, exp);
   endtask

   task automatic expect_none(input string tag);
      bit gv; int gn;
      cyc(1, 0, gv, gn);
      chk(!gv, tag, int'(gv), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      bit gv; int gn;
      int cnt [N];
      void'($urandom(32'd4711));
      for (int i = 0; i < N; i++) wt[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      // R1: outputs idle during reset
      chk(grant_vld == 1'b0, "R1 vld in reset", int'(grant_vld), 0);
      chk(grant_node == '0, "R1 node in reset", int'(grant_node), 0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk(grant_vld == 1'b0, "R1 vld after reset", int'(grant_vld), 0);
      chk(grant_node == '0, "R1 node after reset", int'(grant_node), 0);

      // R4: plain mode alternates between two nodes
      load(16'h0003, 0);
      expect_node(0, "R4 plain 1st"); expect_node(1, "R4 plain 2nd");
      expect_node(0, "R4 plain 3rd"); expect_node(1, "R4 plain 4th");

      // R5 and R10: weights 2,1 back to back
      wt[0] = 8'd2; wt[1] = 8'd1;
      load(16'h0003, 1);
      expect_node(0, "R5 w21 a"); expect_node(0, "R5 w21 b"); expect_node(1, "R5 w21 c");
      expect_node(0, "R10 w21 d"); expect_node(0, "R10 w21 e"); expect_node(1, "R10 w21 f");

      // R5 and R3: nodes 0,2,5 with weights 4,7,9, two full rounds
      wt[0] = 8'd4; wt[2] = 8'd7; wt[5] = 8'd9;
      load(16'h0025, 1);
      for (int i = 0; i < N; i++) cnt[i] = 0;
      for (int i = 0; i < 40; i++) begin
         cyc(1, 0, gv, gn);
         if (gv) cnt[gn]++;
      end
      chk(cnt[0] == 8, "R5 ratio node0", cnt[0], 8);
      chk(cnt[2] == 14, "R5 ratio node2", cnt[2], 14);
      chk(cnt[5] == 18, "R5 ratio node5", cnt[5], 18);
      chk(cnt[1] == 0, "R3 masked node1", cnt[1], 0);

      // R6: a zero weight still earns one grant
      wt[0] = 8'd0; wt[1] = 8'd3;
      load(16'h0003, 1);
      expect_node(0, "R6 zero weight"); expect_node(1, "R6 b"); expect_node(1, "R6 c");
      expect_node(1, "R6 d"); expect_node(0, "R6 zero weight again");

      // R7: fallback in the middle of a run keeps the waiting node's credit
      wt[0] = 8'd3; wt[1] = 8'd1; wt[2] = 8'd1;
      load(16'h0007, 1);
      expect_node(0, "R7 run start");
      avail = 16'hFFFE;
      expect_node(1, "R7 fallback");
      avail = '1;
      expect_node(0, "R7 credit kept a"); expect_node(0, "R7 credit kept b");
      expect_node(1, "R7 turn moves on");
      avail = 16'hFFFB;
      expect_node(0, "R7 wrap fallback");
      // R8: nothing able leaves the state alone
      avail = '0;
      expect_none("R8 none available");
      avail = '1;
      expect_node(2, "R8 state unchanged");
      load(16'h0000, 1);
      expect_none("R8 empty mask");

      // R9: load restarts the run and drops a same-cycle request
      wt[2] = 8'd2; wt[3] = 8'd1;
      load(16'h000C, 1);
      expect_node(2, "R9 start");
      cyc(1, 1, gv, gn);
      chk(!gv, "R9 request dropped on load", int'(gv), 0);
      expect_node(2, "R9 full credit a"); expect_node(2, "R9 full credit b");
      expect_node(3, "R9 next node");

      // random phase
      for (int t = 0; t < 4000; t++) begin
         if ($urandom_range(19) == 0) begin
            for (int i = 0; i < N; i++) wt[i] = W'($urandom_range(5));
            @(negedge clk);
            en_mask = ($urandom_range(3) == 0) ? N'($urandom_range(15)) : N'($urandom);
            weighted = 1'($urandom_range(1));
            cyc(1'($urandom_range(1)), 1, gv, gn);
         end else begin
            avail = ($urandom_range(4) == 0) ? N'($urandom) : '1;
            cyc($urandom_range(9) < 7, 0, gv, gn);
         end
      end

      @(negedge clk); req = 0;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule